// File: doc/BRIEF.md
# Two-Stage PLL Divider Search Engine

This block finds the divider and multiplier codes for a cascaded two-stage frequency synthesizer. Given a reference frequency and a target output frequency, both in hertz, it steps through the five codes in a fixed nested order. The codes are the stage-1 pre-divider `r1`, the stage-1 multiplier `f1`, the stage-2 pre-divider `r2`, the stage-2 multiplier `f2` and the post-divider `q`. Each intermediate frequency is tested against its own legal window. The engine reports the first setting that reaches the target exactly. When no setting does, it reports the legal setting with the smallest error.

A caller pulses `start` with the two frequencies applied. `busy` stays high while the sweep runs, and `done` pulses for one cycle when the results are ready. The results stay on the outputs until the next accepted start. The codes are also given as one packed configuration word that a register stage can load directly. A single shared restoring divider does every division one bit per cycle. The search prunes a branch as soon as an intermediate frequency leaves its window in a direction that cannot recover.

The controller is a single state machine with these states:
- `S_IDLE` waits for `start`.
- `S_R1_DIV`, `S_R2_DIV` and `S_Q_DIV` run a division and wait for it to finish.
- `S_R1_CHK`, `S_F1_CHK`, `S_R2_CHK` and `S_F2_CHK` test a window.
- `S_Q_CHK` judges a candidate.
- `S_ADV_Q`, `S_ADV_F2`, `S_ADV_R2`, `S_ADV_F1` and `S_ADV_R1` step one loop index or fall through to the loop outside it.
- `S_DONE` presents the result for one cycle.

The transitions are:
- `S_IDLE` goes to `S_R1_DIV` on start.
- A division state goes to its check state when the divider finishes.
- A window check leaves to the advance state of the loop outside it when the value is past the top of the window (or, for the reference divisions, below the bottom). It goes to its own advance state when the value is on the other side of the window. Otherwise it descends one loop level.
- `S_Q_CHK` goes to `S_DONE` on an exact hit and otherwise to `S_ADV_Q`.
- `S_ADV_R1` goes to `S_DONE` when `r1` is exhausted, and `S_R1_CHK` does the same when the divided reference is already below its window.

Top module: `pll_div_search`

## Requirements
- R1: After reset, busy, done and exact are 0, and every code output, fout_hz and cfg_word are 0.
- R2: r1 takes values 0 to R1_MAX in increasing order. An r1 is used only when refin/(r1+1), truncated, lies within [REF1_MIN, REF1_MAX] inclusive.
- R3: f1 takes values 0 to F1_MAX. An f1 is used only when vco1 = (refin/(r1+1))·2·(f1+1) lies within [VCO1_MIN, VCO1_MAX] inclusive.
- R4: r2 takes values 0 to R2_MAX. An r2 is used only when vco1/(r2+1), truncated, lies within [REF2_MIN, REF2_MAX] inclusive.
- R5: f2 takes values 0 to F2_MAX and q takes values 0 to Q_LIM-1. vco2 = (vco1/(r2+1))·2·(f2+1) must lie within [VCO2_MIN, VCO2_MAX] inclusive. The candidate output is vco2/(2·(q+1)), truncated.
- R6: Candidates are visited with r1 outermost, then f1, r2, f2 and q innermost. The first candidate equal to fout_request ends the search, and its codes and frequency are reported with exact = 1.
- R7: A non-exact candidate becomes the stored best only when its absolute error is strictly smaller than the stored error. The stored error starts at ERR_INIT, so on a tie the earlier candidate is kept.
- R8: When no exact hit exists, the stored best is reported with exact = 0. When no candidate ever beats ERR_INIT, every code, fout_hz and cfg_word read 0.
- R9: cfg_word carries r1 in bits [27:25], r2 in [24:19], f1 in [18:13], f2 in [12:7] and q in [6:1]. Bits 31:28 and bit 0 are 0.
- R10: A start pulse while busy is 1 is ignored. The running search finishes with the inputs it latched at the accepted start.
- R11: busy rises in the cycle after an accepted start. done is high for exactly one cycle with busy low, as busy falls. All outputs hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search; sampled only when idle |
| refin | input | 32 | Reference frequency in Hz |
| fout_request | input | 32 | Target output frequency in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result-ready pulse |
| r1_code | output | 3 | Stage-1 pre-divider code |
| f1_code | output | 6 | Stage-1 multiplier code |
| r2_code | output | 6 | Stage-2 pre-divider code |
| f2_code | output | 6 | Stage-2 multiplier code |
| q_code | output | 6 | Post-divider code |
| fout_hz | output | 32 | Achieved output frequency in Hz |
| exact | output | 1 | Achieved frequency equals the request |
| cfg_word | output | 32 | Packed divider codes |

## Verification
The bench builds the engine with narrower loops: R1_MAX=3, F1_MAX=7, R2_MAX=5, F2_MAX=2 and Q_LIM=3. It also uses frequency windows in the hundreds to low thousands of hertz, and an initial error of 100000. With these settings a complete sweep with no exact hit runs in a few thousand cycles, so several full sweeps fit in one run. The settings also give every kind of pruning. Some references fall above their window and some below, vco values climb out of range, and the pre-divider loop exits early. Ties between candidates occur often among the small output values, which exercises the strict-improvement rule. A very large request leaves no candidate at all.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

    localparam int CODE_R1_W = 3;
    localparam int CODE_F_W  = 6;

    typedef enum logic [3:0] {
        S_IDLE,
        S_R1_DIV,
        S_R1_CHK,
        S_F1_CHK,
        S_R2_DIV,
        S_R2_CHK,
        S_F2_CHK,
        S_Q_DIV,
        S_Q_CHK,
        S_ADV_Q,
        S_ADV_F2,
        S_ADV_R2,
        S_ADV_F1,
        S_ADV_R1,
        S_DONE
    } srch_state_e;

    typedef struct packed {
        logic [CODE_R1_W-1:0] r1;
        logic [CODE_F_W-1:0]  f1;
        logic [CODE_F_W-1:0]  r2;
        logic [CODE_F_W-1:0]  f2;
        logic [CODE_F_W-1:0]  q;
    } div_codes_t;

    // Field placement is consumed by the synthesizer control register.
    function automatic logic [31:0] pack_cfg(input div_codes_t c);
        return {4'b0000, c.r1, c.r2, c.f1, c.f2, c.q, 1'b0};
    endfunction

endpackage

// File: rtl/pllsrch_div.sv
// Restoring unsigned divider, one quotient bit per cycle.
module pllsrch_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo,
    output logic         ok
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  acc_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [W:0]    shifted;
    logic          fits;

    always_comb begin
        shifted = {rem_q, acc_q[W-1]};
        fits    = shifted >= {1'b0, den};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            acc_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            ok    <= 1'b0;
        end else begin
            ok <= 1'b0;
            if (go) begin
                rem_q <= '0;
                acc_q <= num;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (fits) begin
                    rem_q <= W'(shifted - {1'b0, den});
                end else begin
                    rem_q <= shifted[W-1:0];
                end
                acc_q <= {acc_q[W-2:0], fits};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    ok    <= 1'b1;
                end
            end
        end
    end

    assign quo = acc_q;

endmodule

// File: rtl/pllsrch_win.sv
// Classifies a value against an inclusive [LO, HI] window.
module pllsrch_win #(
    parameter int          W  = 32,
    parameter logic [31:0] LO = 32'd0,
    parameter logic [31:0] HI = 32'hFFFF_FFFF
) (
    input  logic [W-1:0] val,
    output logic         below,
    output logic         above
);
    localparam logic [W-1:0] LO_X = W'(LO);
    localparam logic [W-1:0] HI_X = W'(HI);

    always_comb begin
        below = val < LO_X;
        above = val > HI_X;
    end
endmodule

// File: rtl/pllsrch_judge.sv
// Error measurement of a candidate against the request.
module pllsrch_judge #(
    parameter int W = 32
) (
    input  logic [W-1:0] cand,
    input  logic [W-1:0] req,
    input  logic [W:0]   best_err,
    output logic         hit,
    output logic         better,
    output logic [W:0]   err_abs
);
    logic signed [W:0] diff;

    always_comb begin
        diff    = $signed({1'b0, cand}) - $signed({1'b0, req});
        err_abs = diff[W] ? $unsigned(-diff) : $unsigned(diff);
        hit     = cand == req;
        better  = err_abs < best_err;
    end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pllsrch_pkg::*;
#(
    parameter int          R1_MAX   = 7,
    parameter int          F1_MAX   = 63,
    parameter int          R2_MAX   = 63,
    parameter int          F2_MAX   = 63,
    parameter int          Q_LIM    = 63,
    parameter logic [31:0] REF1_MIN = 32'd25_000_000,
    parameter logic [31:0] REF1_MAX = 32'd54_000_000,
    parameter logic [31:0] VCO1_MIN = 32'd1_600_000_000,
    parameter logic [31:0] VCO1_MAX = 32'd2_400_000_000,
    parameter logic [31:0] REF2_MIN = 32'd54_000_000,
    parameter logic [31:0] REF2_MAX = 32'd75_000_000,
    parameter logic [31:0] VCO2_MIN = 32'd1_200_000_000,
    parameter logic [31:0] VCO2_MAX = 32'd2_400_000_000,
    parameter logic [31:0] ERR_INIT = 32'd600_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] refin,
    input  logic [31:0] fout_request,
    output logic        busy,
    output logic        done,
    output logic [2:0]  r1_code,
    output logic [5:0]  f1_code,
    output logic [5:0]  r2_code,
    output logic [5:0]  f2_code,
    output logic [5:0]  q_code,
    output logic [31:0] fout_hz,
    output logic        exact,
    output logic [31:0] cfg_word
);
    localparam int W    = 32;
    localparam int R1_W = CODE_R1_W;
    localparam int F_W  = CODE_F_W;

    srch_state_e state_q, state_n;

    logic [R1_W-1:0] r1_q;
    logic [F_W-1:0]  f1_q, r2_q, f2_q, q_q;
    logic [W-1:0]    refin_q, req_q;
    logic [W-1:0]    ref1_q, ref2_q, fout_q;
    logic [W:0]      vco1_q, vco2_q;
    logic [W:0]      best_err_q;
    logic            launched_q;
    div_codes_t      res_q;
    logic [W-1:0]    res_fout_q;
    logic            res_exact_q;

    logic            div_go, div_ok;
    logic [W-1:0]    div_num, div_den, div_quo;
    logic            is_div;

    logic ref1_lo, ref1_hi, vco1_lo, vco1_hi;
    logic ref2_lo, ref2_hi, vco2_lo, vco2_hi;
    logic cand_hit, cand_better;
    logic [W:0] cand_err;

    pllsrch_win #(.W(W),   .LO(REF1_MIN), .HI(REF1_MAX)) u_w_ref1 (
        .val(ref1_q), .below(ref1_lo), .above(ref1_hi));
    pllsrch_win #(.W(W+1), .LO(VCO1_MIN), .HI(VCO1_MAX)) u_w_vco1 (
        .val(vco1_q), .below(vco1_lo), .above(vco1_hi));
    pllsrch_win #(.W(W),   .LO(REF2_MIN), .HI(REF2_MAX)) u_w_ref2 (
        .val(ref2_q), .below(ref2_lo), .above(ref2_hi));
    pllsrch_win #(.W(W+1), .LO(VCO2_MIN), .HI(VCO2_MAX)) u_w_vco2 (
        .val(vco2_q), .below(vco2_lo), .above(vco2_hi));

    pllsrch_judge #(.W(W)) u_judge (
        .cand     (fout_q),
        .req      (req_q),
        .best_err (best_err_q),
        .hit      (cand_hit),
        .better   (cand_better),
        .err_abs  (cand_err)
    );

    pllsrch_div #(.W(W)) u_div (
        .clk (clk),
        .rst (rst),
        .go  (div_go),
        .num (div_num),
        .den (div_den),
        .quo (div_quo),
        .ok  (div_ok)
    );

    // Divider operand selection: one launch per entry into a division state.
    always_comb begin
        is_div  = (state_q == S_R1_DIV) || (state_q == S_R2_DIV) || (state_q == S_Q_DIV);
        div_go  = is_div && !launched_q;
        div_num = refin_q;
        div_den = W'(r1_q) + W'(1);
        if (state_q == S_R2_DIV) begin
            div_num = vco1_q[W-1:0];
            div_den = W'(r2_q) + W'(1);
        end else if (state_q == S_Q_DIV) begin
            div_num = vco2_q[W-1:0];
            div_den = {W'(q_q), 1'b0}[W-1:0] + W'(2);
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_n = S_R1_DIV;
            S_R1_DIV: if (div_ok) state_n = S_R1_CHK;
            S_R1_CHK: begin
                if (ref1_lo)      state_n = S_DONE;     // later r1 only smaller
                else if (ref1_hi) state_n = S_ADV_R1;
                else              state_n = S_F1_CHK;
            end
            S_F1_CHK: begin
                if (vco1_hi)      state_n = S_ADV_R1;   // later f1 only larger
                else if (vco1_lo) state_n = S_ADV_F1;
                else              state_n = S_R2_DIV;
            end
            S_R2_DIV: if (div_ok) state_n = S_R2_CHK;
            S_R2_CHK: begin
                if (ref2_lo)      state_n = S_ADV_F1;   // later r2 only smaller
                else if (ref2_hi) state_n = S_ADV_R2;
                else              state_n = S_F2_CHK;
            end
            S_F2_CHK: begin
                if (vco2_hi)      state_n = S_ADV_R2;   // later f2 only larger
                else if (vco2_lo) state_n = S_ADV_F2;
                else              state_n = S_Q_DIV;
            end
            S_Q_DIV:  if (div_ok) state_n = S_Q_CHK;
            S_Q_CHK:  state_n = cand_hit ? S_DONE : S_ADV_Q;
            S_ADV_Q:  state_n = (int'(q_q)  < Q_LIM - 1) ? S_Q_DIV  : S_ADV_F2;
            S_ADV_F2: state_n = (int'(f2_q) < F2_MAX)    ? S_F2_CHK : S_ADV_R2;
            S_ADV_R2: state_n = (int'(r2_q) < R2_MAX)    ? S_R2_DIV : S_ADV_F1;
            S_ADV_F1: state_n = (int'(f1_q) < F1_MAX)    ? S_F1_CHK : S_ADV_R1;
            S_ADV_R1: state_n = (int'(r1_q) < R1_MAX)    ? S_R1_DIV : S_DONE;
            S_DONE:   state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    // Loop indices, intermediate frequencies and the stored best
    always_ff @(posedge clk) begin
        if (rst) begin
            r1_q        <= '0;
            f1_q        <= '0;
            r2_q        <= '0;
            f2_q        <= '0;
            q_q         <= '0;
            refin_q     <= '0;
            req_q       <= '0;
            ref1_q      <= '0;
            ref2_q      <= '0;
            fout_q      <= '0;
            vco1_q      <= '0;
            vco2_q      <= '0;
            best_err_q  <= '0;
            launched_q  <= 1'b0;
            res_q       <= '0;
            res_fout_q  <= '0;
            res_exact_q <= 1'b0;
        end else begin
            if (div_go) launched_q <= 1'b1;
            if (div_ok) launched_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        refin_q     <= refin;
                        req_q       <= fout_request;
                        r1_q        <= '0;
                        best_err_q  <= (W+1)'(ERR_INIT);
                        res_q       <= '0;
                        res_fout_q  <= '0;
                        res_exact_q <= 1'b0;
                    end
                end
                S_R1_DIV: if (div_ok) ref1_q <= div_quo;
                S_R1_CHK: begin
                    f1_q   <= '0;
                    vco1_q <= {ref1_q, 1'b0};
                end
                S_F1_CHK: r2_q <= '0;
                S_R2_DIV: if (div_ok) ref2_q <= div_quo;
                S_R2_CHK: begin
                    f2_q   <= '0;
                    vco2_q <= {ref2_q, 1'b0};
                end
                S_F2_CHK: q_q <= '0;
                S_Q_DIV:  if (div_ok) fout_q <= div_quo;
                S_Q_CHK: begin
                    if (cand_hit || cand_better) begin
                        res_q       <= '{r1: r1_q, f1: f1_q, r2: r2_q, f2: f2_q, q: q_q};
                        res_fout_q  <= fout_q;
                        res_exact_q <= cand_hit;
                        best_err_q  <= cand_err;
                    end
                end
                S_ADV_Q:  if (int'(q_q) < Q_LIM - 1) q_q <= q_q + F_W'(1);
                S_ADV_F2: begin
                    if (int'(f2_q) < F2_MAX) begin
                        f2_q   <= f2_q + F_W'(1);
                        vco2_q <= vco2_q + {ref2_q, 1'b0};
                    end
                end
                S_ADV_R2: if (int'(r2_q) < R2_MAX) r2_q <= r2_q + F_W'(1);
                S_ADV_F1: begin
                    if (int'(f1_q) < F1_MAX) begin
                        f1_q   <= f1_q + F_W'(1);
                        vco1_q <= vco1_q + {ref1_q, 1'b0};
                    end
                end
                S_ADV_R1: if (int'(r1_q) < R1_MAX) r1_q <= r1_q + R1_W'(1);
                S_DONE:   ;
                default:  ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy     = (state_q != S_IDLE) && (state_q != S_DONE);
        done     = state_q == S_DONE;
        r1_code  = res_q.r1;
        f1_code  = res_q.f1;
        r2_code  = res_q.r2;
        f2_code  = res_q.f2;
        q_code   = res_q.q;
        fout_hz  = res_fout_q;
        exact    = res_exact_q;
        cfg_word = pack_cfg(res_q);
    end

endmodule

// File: rtl/pllsrch_chk.sv
module pllsrch_chk #(
    parameter int          R1_MAX   = 7,
    parameter int          Q_LIM    = 63,
    parameter logic [31:0] ERR_INIT = 32'd600_000_000
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        exact,
    input logic [31:0] fout_hz,
    input logic [31:0] fout_request,
    input logic [2:0]  r1_code,
    input logic [5:0]  q_code
);
    logic [32:0] gap;

    always_comb begin
        gap = (fout_hz >= fout_request) ? {1'b0, fout_hz - fout_request}
                                        : {1'b0, fout_request - fout_hz};
    end

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_busy_ends_done_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done && !start) |=> ($stable(fout_hz) && $stable(exact)));

    assert_exact_match_R6: assert property (@(posedge clk) disable iff (rst)
        (done && exact) |-> (fout_hz == fout_request));

    assert_inexact_differs_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !exact) |-> (fout_hz != fout_request));

    assert_q_range_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(q_code) < Q_LIM));

    assert_r1_range_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(r1_code) <= R1_MAX));

    assert_best_error_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !exact && fout_hz != 32'd0) |-> (gap < {1'b0, ERR_INIT}));

endmodule

bind pll_div_search pllsrch_chk #(
    .R1_MAX   (R1_MAX),
    .Q_LIM    (Q_LIM),
    .ERR_INIT (ERR_INIT)
) u_chk (.*);

// File: tb/pll_div_search_bench.sv
module pll_div_search_bench;

    localparam int     B_R1_MAX = 3;
    localparam int     B_F1_MAX = 7;
    localparam int     B_R2_MAX = 5;
    localparam int     B_F2_MAX = 2;
    localparam int     B_Q_LIM  = 3;
    localparam longint B_REF1_MIN = 100,  B_REF1_MAX = 200;
    localparam longint B_VCO1_MIN = 1000, B_VCO1_MAX = 2000;
    localparam longint B_REF2_MIN = 150,  B_REF2_MAX = 300;
    localparam longint B_VCO2_MIN = 600,  B_VCO2_MAX = 1500;
    localparam longint B_ERR_INIT = 100000;

    localparam int NVEC = 6;
    localparam logic [31:0] VEC_REF [NVEC] = '{32'd400, 32'd400, 32'd400, 32'd350, 32'd600, 32'd257};
    localparam logic [31:0] VEC_REQ [NVEC] = '{32'd270, 32'd5000, 32'd1, 32'd333, 32'd250, 32'd123};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] refin = '0;
    logic [31:0] fout_request = '0;
    logic        busy, done, exact;
    logic [2:0]  r1_code;
    logic [5:0]  f1_code, r2_code, f2_code, q_code;
    logic [31:0] fout_hz, cfg_word;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    pll_div_search #(
        .R1_MAX(B_R1_MAX), .F1_MAX(B_F1_MAX), .R2_MAX(B_R2_MAX),
        .F2_MAX(B_F2_MAX), .Q_LIM(B_Q_LIM),
        .REF1_MIN(32'(B_REF1_MIN)), .REF1_MAX(32'(B_REF1_MAX)),
        .VCO1_MIN(32'(B_VCO1_MIN)), .VCO1_MAX(32'(B_VCO1_MAX)),
        .REF2_MIN(32'(B_REF2_MIN)), .REF2_MAX(32'(B_REF2_MAX)),
        .VCO2_MIN(32'(B_VCO2_MIN)), .VCO2_MAX(32'(B_VCO2_MAX)),
        .ERR_INIT(32'(B_ERR_INIT))
    ) u_pll_div_search (
        .clk(clk), .rst(rst), .start(start), .refin(refin),
        .fout_request(fout_request), .busy(busy), .done(done),
        .r1_code(r1_code), .f1_code(f1_code), .r2_code(r2_code),
        .f2_code(f2_code), .q_code(q_code), .fout_hz(fout_hz),
        .exact(exact), .cfg_word(cfg_word)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 195000) begin
            $display("FAIL watchdog expired act=%0d exp=<195000", cyc);
            $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
            $finish;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic longint labs(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    // Reference search straight from the requirements (R2..R8).
    function automatic void model(input longint rin, input longint req,
                                  output longint m_r1, output longint m_f1,
                                  output longint m_r2, output longint m_f2,
                                  output longint m_q, output longint m_fo,
                                  output bit m_ex);
        longint best = B_ERR_INIT;
        m_r1 = 0; m_f1 = 0; m_r2 = 0; m_f2 = 0; m_q = 0; m_fo = 0; m_ex = 0;
        for (int a = 0; a <= B_R1_MAX; a++) begin
            longint ref1 = rin / (a + 1);
            if (ref1 < B_REF1_MIN || ref1 > B_REF1_MAX) continue;
            for (int b = 0; b <= B_F1_MAX; b++) begin
                longint v1 = ref1 * 2 * (b + 1);
                if (v1 < B_VCO1_MIN || v1 > B_VCO1_MAX) continue;
                for (int c = 0; c <= B_R2_MAX; c++) begin
                    longint ref2 = v1 / (c + 1);
                    if (ref2 < B_REF2_MIN || ref2 > B_REF2_MAX) continue;
                    for (int d = 0; d <= B_F2_MAX; d++) begin
                        longint v2 = ref2 * 2 * (d + 1);
                        if (v2 < B_VCO2_MIN || v2 > B_VCO2_MAX) continue;
                        for (int e = 0; e < B_Q_LIM; e++) begin
                            longint fo = v2 / (2 * (e + 1));
                            if (fo == req) begin
                                m_r1 = a; m_f1 = b; m_r2 = c; m_f2 = d; m_q = e;
                                m_fo = fo; m_ex = 1;
                                return;
                            end else if (labs(fo - req) < best) begin
                                best = labs(fo - req);
                                m_r1 = a; m_f1 = b; m_r2 = c; m_f2 = d; m_q = e;
                                m_fo = fo;
                            end
                        end
                    end
                end
            end
        end
    endfunction

    task automatic launch(input logic [31:0] rin, input logic [31:0] req);
        @(negedge clk);
        refin = rin;
        fout_request = req;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11 busy after start", longint'(busy), 1);
    endtask

    task automatic wait_done();
        bit seen = 0;
        for (int n = 0; n < 60000; n++) begin
            if (done) begin
                seen = 1;
                break;
            end
            @(negedge clk);
        end
        chk("R11 done reached", longint'(seen), 1);
    endtask

    task automatic check_vs_model(input string tag, input logic [31:0] rin,
                                  input logic [31:0] req);
        longint e_r1, e_f1, e_r2, e_f2, e_q, e_fo;
        bit e_ex;
        longint e_cfg;
        model(longint'(rin), longint'(req), e_r1, e_f1, e_r2, e_f2, e_q, e_fo, e_ex);
        e_cfg = (e_r1 << 25) | (e_r2 << 19) | (e_f1 << 13) | (e_f2 << 7) | (e_q << 1);
        chk({tag, " R2 r1"}, longint'(r1_code), e_r1);
        chk({tag, " R3 f1"}, longint'(f1_code), e_f1);
        chk({tag, " R4 r2"}, longint'(r2_code), e_r2);
        chk({tag, " R5 f2"}, longint'(f2_code), e_f2);
        chk({tag, " R5 q"},  longint'(q_code),  e_q);
        chk({tag, " R7 fout"}, longint'(fout_hz), e_fo);
        chk({tag, " R6 exact"}, longint'(exact), longint'(e_ex));
        chk({tag, " R9 cfg"}, longint'(cfg_word), e_cfg);
    endtask

    task automatic after_done();
        @(negedge clk);
        chk("R11 done one cycle", longint'(done), 0);
        chk("R11 idle after done", longint'(busy), 0);
    endtask

    initial begin
        logic [31:0] hold_fout, hold_cfg;
        logic        hold_ex;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", longint'(busy), 0);
        chk("R1 done", longint'(done), 0);
        chk("R1 exact", longint'(exact), 0);
        chk("R1 fout", longint'(fout_hz), 0);
        chk("R1 cfg", longint'(cfg_word), 0);

        // Table walk: every vector compared with the reference search.
        for (int i = 0; i < NVEC; i++) begin
            launch(VEC_REF[i], VEC_REQ[i]);
            wait_done();
            check_vs_model($sformatf("vec%0d", i), VEC_REF[i], VEC_REQ[i]);
            after_done();
        end

        // Hand-derived exact hit: r1=1 (ref 200), f1=2 (vco1 1200), r2=3 (ref2 300), f2=0, q=0.
        launch(32'd400, 32'd300);
        wait_done();
        chk("R6 hand exact", longint'(exact), 1);
        chk("R6 hand fout", longint'(fout_hz), 300);
        chk("R2 hand r1", longint'(r1_code), 1);
        chk("R3 hand f1", longint'(f1_code), 2);
        chk("R4 hand r2", longint'(r2_code), 3);
        chk("R5 hand q", longint'(q_code), 0);
        chk("R9 hand cfg", longint'(cfg_word), 64'h0218_4000);
        after_done();

        // R11: outputs hold while idle, even with input changes.
        hold_fout = fout_hz;
        hold_cfg  = cfg_word;
        hold_ex   = exact;
        refin = 32'd777;
        fout_request = 32'd5;
        repeat (6) @(negedge clk);
        chk("R11 hold fout", longint'(fout_hz), longint'(hold_fout));
        chk("R11 hold cfg", longint'(cfg_word), longint'(hold_cfg));
        chk("R11 hold exact", longint'(exact), longint'(hold_ex));

        // R10: a start while busy with other inputs is ignored.
        launch(32'd400, 32'd300);
        refin = 32'd999;
        fout_request = 32'd1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        refin = 32'd400;
        fout_request = 32'd300;
        wait_done();
        chk("R10 ignored start fout", longint'(fout_hz), 300);
        chk("R10 ignored start cfg", longint'(cfg_word), 64'h0218_4000);
        after_done();
        chk("R10 no restart", longint'(busy), 0);

        // R8: request far beyond every candidate, nothing beats the initial error.
        launch(32'd400, 32'd200000);
        wait_done();
        chk("R8 none exact", longint'(exact), 0);
        chk("R8 none fout", longint'(fout_hz), 0);
        chk("R8 none cfg", longint'(cfg_word), 0);
        after_done();

        // R2: reference below the stage-1 window at r1=0 ends the search with nothing.
        launch(32'd50, 32'd50);
        wait_done();
        chk("R2 low ref fout", longint'(fout_hz), 0);
        chk("R2 low ref exact", longint'(exact), 0);
        after_done();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule